// File: doc/BRIEF.md
# Delay-Line Time-to-Digital Capture Encoder

This block turns the state of a buffer delay line into a binary voltage code, once per conversion period of a digital regulator loop. Each period has two phases. While the charge phase input is low, a sensing capacitor pre-charges and the capture flops are held clear. When it goes high, a logic one enters the delay line and begins to pass through the buffers. The capacitor charges at the same time, and when the sensor comparator output rises, every tap flop captures its own tap at once. The number of buffers the one has passed through is proportional to the sensed voltage, at roughly 25 mV per step.

A controller clock domain then reads the frozen tap vector. The block learns that a capture took place through a two-flop synchronised flag. It counts the ones in the captured pattern, so a stray zero or one among the taps moves the result by only one step. Counts above the code range are clamped. The result is registered together with a one-cycle valid strobe. If the sensor never fires during a charge phase, the block reports full scale when that phase ends.

The loop controller takes the code and valid strobe directly, subtracts the code from its reference and adjusts the pass-device array.

Top module: `tdc_capture_encoder`

## Requirements
- R1: While rstN is low, codeO is 0 and validO is 0.
- R2: After a rising sensorEdge during a charge phase (chargePhase high), validO is high on the third rising clk edge. codeO then equals the number of ones in tapIn at the moment of the sensor edge, where tapIn bit 0 is the tap nearest the launch point.
- R3: The code is the total count of ones in the captured taps wherever they sit, so a thermometer pattern with bubbles gives its ones count.
- R4: A captured count above 63 (all 64 taps set) gives codeO = 63.
- R5: If no sensor edge arrives during a charge phase, validO is high with codeO = 63 on the third rising clk edge after chargePhase falls.
- R6: validO is high for exactly one clk cycle. There is at most one valid pulse per charge phase, and codeO holds its value whenever validO is low.
- R7: A sensor edge while chargePhase is low captures nothing. No valid pulse follows it and codeO is unchanged.
- R8: Changes on tapIn after the sensor edge has captured it do not affect the reported code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chargePhase | input | 1 | High during the charge and convert phase, low during pre-charge |
| sensorEdge | input | 1 | Voltage-sensor comparator output; its rising edge captures the taps |
| tapIn | input | 64 | Delay-line tap levels, bit 0 nearest the launch point |
| codeO | output | 6 | Registered binary voltage code |
| validO | output | 1 | One-cycle strobe marking a new code |

## Verification
A captured code is due on the third rising clk edge after the sensor edge: two synchroniser stages and then the output register. A full-scale result on a missed edge is due on the third rising clk edge after chargePhase falls. The bench changes every input on a falling clock edge and counts three falling edges before it samples. This places each sample half a cycle after the register that produces the result has updated. One falling edge later it samples again to confirm the strobe has dropped. A running count of valid pulses, also taken on falling edges, shows that each period yields exactly one result.

// File: rtl/tdc_enc_pkg.sv
package tdc_enc_pkg;

  // Load strobes sent from the control path to the datapath
  typedef struct packed {
    logic loadCount;  // load the clamped ones-count of the captured taps
    logic loadFull;   // load full scale (no sensor edge seen this period)
  } tdcStrobe_t;

endpackage

// File: rtl/tdc_tap_capture.sv
// Tap flops clocked by the sensor comparator edge. They are held clear while
// clrN is low, i.e. during pre-charge or reset.
module tdc_tap_capture #(
  parameter int NUM_TAPS = 64
) (
  input  logic                sensorEdge,
  input  logic                clrN,
  input  logic [NUM_TAPS-1:0] tapIn,
  output logic [NUM_TAPS-1:0] tapHeld,
  output logic                capFlag
);

  always_ff @(posedge sensorEdge or negedge clrN) begin
    if (!clrN) begin
      tapHeld <= '0;
      capFlag <= 1'b0;
    end else begin
      tapHeld <= tapIn;
      capFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/tdc_enc_ctrl.sv
// Brings the capture flag and the phase level into the clk domain. It detects
// a capture, and it detects the end of a charge phase in which no capture came.
module tdc_enc_ctrl
  import tdc_enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capFlag,
  input  logic       chargePhase,
  output tdcStrobe_t strobe
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] capSync;
  logic [SYNC_STAGES-1:0] phSync;
  logic                   capPrev;
  logic                   phPrev;
  logic                   gotCode;
  logic                   capRise;
  logic                   phFall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          capSync <= '0;
          phSync  <= '0;
        end else begin
          capSync <= {capSync[SYNC_STAGES-2:0], capFlag};
          phSync  <= {phSync[SYNC_STAGES-2:0], chargePhase};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          capSync <= '0;
          phSync  <= '0;
        end else begin
          capSync <= capFlag;
          phSync  <= chargePhase;
        end
      end
    end
  endgenerate

  assign capRise = capSync[LAST] & ~capPrev;
  assign phFall  = ~phSync[LAST] & phPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPrev <= 1'b0;
      phPrev  <= 1'b0;
      gotCode <= 1'b0;
    end else begin
      capPrev <= capSync[LAST];
      phPrev  <= phSync[LAST];
      if (phFall)       gotCode <= 1'b0;
      else if (capRise) gotCode <= 1'b1;
    end
  end

  // A capture takes priority. Full scale is loaded only for a phase without one.
  always_comb begin
    strobe.loadCount = capRise;
    strobe.loadFull  = phFall & ~gotCode & ~capRise;
  end

endmodule

// File: rtl/tdc_enc_datapath.sv
// Counts the ones in the captured taps, clamps the count to the code range,
// and registers the code and the valid strobe.
module tdc_enc_datapath
  import tdc_enc_pkg::*;
#(
  parameter int NUM_TAPS = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tdcStrobe_t                  strobe,
  input  logic [NUM_TAPS-1:0]         tapHeld,
  output logic [$clog2(NUM_TAPS)-1:0] codeO,
  output logic                        validO
);

  localparam int CODE_W = $clog2(NUM_TAPS);
  localparam int CNT_W  = $clog2(NUM_TAPS + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'((1 << CODE_W) - 1);

  logic [CNT_W-1:0]  popCnt;
  logic [CODE_W-1:0] codeSat;

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      popCnt = popCnt + CNT_W'(tapHeld[i]);
    end
  end

  assign codeSat = (popCnt > MAX_CNT) ? '1 : popCnt[CODE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeO  <= '0;
      validO <= 1'b0;
    end else begin
      validO <= strobe.loadCount | strobe.loadFull;
      if (strobe.loadCount)     codeO <= codeSat;
      else if (strobe.loadFull) codeO <= '1;
    end
  end

endmodule

// File: rtl/tdc_capture_encoder.sv
module tdc_capture_encoder
  import tdc_enc_pkg::*;
#(
  parameter int NUM_TAPS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        chargePhase,
  input  logic                        sensorEdge,
  input  logic [NUM_TAPS-1:0]         tapIn,
  output logic [$clog2(NUM_TAPS)-1:0] codeO,
  output logic                        validO
);

  localparam int CODE_W = $clog2(NUM_TAPS);

  logic [NUM_TAPS-1:0] tapHeld;
  logic                capFlag;
  logic                clrN;
  tdcStrobe_t          strobe;

  // Tap flops are clear outside the charge phase and during reset
  assign clrN = rstN & chargePhase;

  tdc_tap_capture #(.NUM_TAPS(NUM_TAPS)) u_cap (
    .sensorEdge (sensorEdge),
    .clrN       (clrN),
    .tapIn      (tapIn),
    .tapHeld    (tapHeld),
    .capFlag    (capFlag)
  );

  tdc_enc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .capFlag     (capFlag),
    .chargePhase (chargePhase),
    .strobe      (strobe)
  );

  tdc_enc_datapath #(.NUM_TAPS(NUM_TAPS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .tapHeld (tapHeld),
    .codeO   (codeO),
    .validO  (validO)
  );

endmodule

// File: rtl/tdc_encoder_checker.sv
module tdc_encoder_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] codeO,
  input logic              validO,
  input logic              loadCount,
  input logic              loadFull
);

  // R1: outputs are at their reset values while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_state_r1: assert (codeO == '0 && !validO)
        else $error("reset state violated");
    end
  end

  // R2: a detected capture produces a valid strobe on the next edge
  p_count_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    loadCount |=> validO);

  // R5: a period without a capture reports full scale
  p_full_scale_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadFull |=> (validO && codeO == {CODE_W{1'b1}}));

  // R6: the strobe lasts a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    validO |=> !validO);

  // R6: the code only moves together with a valid strobe
  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !validO |-> $stable(codeO));

  // R6: never two kinds of result in one cycle
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadCount, loadFull}));

endmodule

bind tdc_capture_encoder tdc_encoder_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .codeO     (codeO),
  .validO    (validO),
  .loadCount (strobe.loadCount),
  .loadFull  (strobe.loadFull)
);

// File: tb/sim_tdc_capture_encoder.sv
module sim_tdc_capture_encoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chargePhase = 1'b0;
  logic        sensorEdge = 1'b0;
  logic [63:0] tapIn = '0;
  logic [5:0]  codeO;
  logic        validO;

  int nChecks = 0;
  int nErr    = 0;
  int pulses  = 0;
  bit done    = 0;

  always #10 clk = ~clk;  // 50 MHz

  tdc_capture_encoder u0 (
    .clk(clk), .rstN(rstN), .chargePhase(chargePhase),
    .sensorEdge(sensorEdge), .tapIn(tapIn), .codeO(codeO), .validO(validO)
  );

  always @(negedge clk) if (rstN && validO) pulses++;

  // {kind, pattern, expected}: kind 0 -> R2, 1 -> R3 (bubbles), 2 -> R4 (clamp)
  localparam logic [71:0] VEC [0:7] = '{
    {2'd0, 64'h0000_0000_0000_0000, 6'd0},
    {2'd0, 64'h0000_0000_0000_0001, 6'd1},
    {2'd0, 64'h0000_0000_00FF_FFFF, 6'd24},
    {2'd0, 64'h0000_FFFF_FFFF_FFFF, 6'd48},
    {2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 6'd63},
    {2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63},
    {2'd1, 64'h0000_0000_0000_0FEF, 6'd11},
    {2'd1, 64'h0000_0000_00FF_F7FF, 6'd23}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runConv(input logic [63:0] pat, input int exp,
                         input string tag, input bit scramble);
    int startPulses;
    @(negedge clk);
    chargePhase = 1'b0;
    sensorEdge  = 1'b0;
    repeat (4) @(negedge clk);
    chargePhase = 1'b1;
    tapIn       = pat;
    repeat (2) @(negedge clk);
    startPulses = pulses;
    sensorEdge  = 1'b1;
    @(negedge clk);
    if (scramble) tapIn = ~pat;
    repeat (2) @(negedge clk);
    check(tag, codeO, exp);
    check({tag, " valid"}, validO, 1);
    @(negedge clk);
    check("R6 valid drop", validO, 0);
    repeat (3) @(negedge clk);
    chargePhase = 1'b0;
    sensorEdge  = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 single pulse", pulses - startPulses, 1);
    check("R6 code hold", codeO, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 code", codeO, 0);
    check("R1 valid", validO, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 code after release", codeO, 0);

    for (int i = 0; i < 8; i++) begin
      string tag;
      tag = (VEC[i][71:70] == 2'd1) ? "R3" : (VEC[i][71:70] == 2'd2) ? "R4" : "R2";
      runConv(VEC[i][69:6], int'(VEC[i][5:0]), tag, 1'b0);
    end

    // R8: taps change after capture; code still reflects the capture moment
    runConv(64'h0000_0000_0000_03FF, 10, "R8", 1'b1);

    // R7: sensor edge during pre-charge is ignored
    begin
      int p0;
      @(negedge clk);
      chargePhase = 1'b0;
      tapIn = '1;
      p0 = pulses;
      repeat (2) @(negedge clk);
      sensorEdge = 1'b1;
      repeat (2) @(negedge clk);
      sensorEdge = 1'b0;
      repeat (5) @(negedge clk);
      check("R7 no pulse", pulses - p0, 0);
      check("R7 code unchanged", codeO, 10);
    end

    // R5: charge phase with no sensor edge gives full scale
    begin
      int p0;
      chargePhase = 1'b1;
      tapIn = 64'h0000_0000_0000_000F;
      repeat (6) @(negedge clk);
      p0 = pulses;
      chargePhase = 1'b0;
      repeat (3) @(negedge clk);
      check("R5 code", codeO, 63);
      check("R5 valid", validO, 1);
      @(negedge clk);
      check("R5 valid drop", validO, 0);
      repeat (4) @(negedge clk);
      check("R5 single pulse", pulses - p0, 1);
    end

    // R2 after a full-scale period: a normal capture works again
    runConv(64'h0000_0000_0000_001F, 5, "R2 after miss", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule